// File: doc/BRIEF.md
# DAC Threshold Calibration Sequencer

This block finds the switching point of an external comparator. It drives one channel of a dual 12-bit serial DAC and raises the DAC code one step at a time until the comparator reports a trip.

The search runs twice. The first pass runs while a bright stimulus is applied and the second while a dark stimulus is applied. The trip code of each pass is stored. The block then programs the DAC with the midpoint of the two stored codes, which becomes the operating threshold. Before each pass the block asks the surrounding logic to apply the stimulus, and it waits for an acknowledge before it writes anything.

A run starts through a valid/ready handshake. A request is accepted only in the cycle where `start_valid` and `start_ready` are both high, and `start_ready` is high only while the block is idle, so a request made during a run is held off. The stimulus handshake works the other way round. `phase_req` and `phase_dark` stay asserted and stable until the requester sees `phase_ack`, and no serial frame is sent in that time.

Every DAC write is one 16-bit serial frame. The frame loads the input register of the selected channel and updates the DAC registers. The DAC output therefore moves when chip select rises at the end of the frame. After each write the block waits a programmable number of settle cycles and then samples the synchronized comparator.

Top module: `thresh_cal_seq`

## Requirements
- R1: After reset, `spi_cs_n` is 1 and `spi_sclk` is 0. `start_ready` is 1, `phase_req`, `cal_done` and `cal_err` are 0, and all three code outputs are 0.
- R2: Each frame is 16 bits, sent MSB first with `spi_cs_n` low for the whole frame. The bits are: the channel bit `CHAN`, then the control bits 1 and 0, then the code zero-extended to a 12-bit field (MSB first), then a 0 sub bit. `spi_din` is stable while `spi_sclk` is high.
- R3: Each frame has exactly 16 rising edges of `spi_sclk`. Every high phase of `spi_sclk` lasts `SCLK_DIV` system clocks. `spi_cs_n` stays low for 33*`SCLK_DIV` clocks, and `spi_sclk` is low whenever `spi_cs_n` is high.
- R4: The bright pass writes codes 0, 1, 2, ... in order. The pass stops at the first code for which the synchronized comparator reads 1 after the settle wait, and `bright_code` takes that code.
- R5: The dark pass starts after the second stimulus handshake. It ramps from 0 in the same way and stores its trip code in `dark_code`.
- R6: After the dark trip, one more frame writes (bright + dark) >> 1. The sum is formed one bit wider than the code, so no carry is lost. When that frame ends, `final_code` shows the midpoint and `cal_done` rises.
- R7: If a pass writes code 2^`DAC_W`-1 without a trip, `cal_err` rises and the block returns to idle. The pass that failed does not change its stored code, and no midpoint frame is sent.
- R8: `phase_req` stays high and `phase_dark` stays stable until `phase_ack` is seen. `phase_dark` is 0 for the bright pass and 1 for the dark pass. No frame is sent while the request is pending.
- R9: `start_ready` is low for the whole run. A `start_valid` pulse during a run has no effect on the frames or on the results.
- R10: Between the end of one ramp frame and the start of the next frame in the same pass, `spi_cs_n` stays high for exactly `settle_cycles`+3 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Request to begin a calibration run |
| start_ready | output | 1 | High when idle and able to accept a start |
| phase_req | output | 1 | Asks for the stimulus of the next pass to be applied |
| phase_dark | output | 1 | Stimulus requested: 0 bright, 1 dark |
| phase_ack | input | 1 | Stimulus is in place and the pass may begin |
| settle_cycles | input | SETTLE_W | Clocks to wait after each write before sampling the comparator (at least 1) |
| cmp_in | input | 1 | Asynchronous comparator output |
| spi_cs_n | output | 1 | Serial chip select, active low |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_din | output | 1 | Serial data to the DAC |
| bright_code | output | DAC_W | Stored trip code from the bright pass |
| dark_code | output | DAC_W | Stored trip code from the dark pass |
| final_code | output | DAC_W | Midpoint code written last |
| cal_done | output | 1 | Run finished with a midpoint written (held until the next start) |
| cal_err | output | 1 | A pass reached the top code without a trip (held until the next start) |

## Verification
The bench builds the block with `DAC_W`=6 and `SCLK_DIV`=2. This makes a full ramp to the top code only 64 short frames long. As a result the no-trip exhaustion in either pass, a trip at the top code, and the largest possible midpoint sum can all be run in a short simulation.

A DAC model in the bench decodes each frame and drives the comparator from a per-pass threshold. The runs use the settle counts 1 and 3. A settle count of 1 is the smallest for which the synchronizer delivers the new comparator value in time.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  localparam int FRAME_W      = 16;
  localparam int CODE_FIELD_W = 12;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_REQ,
    SQ_WRITE,
    SQ_SETTLE,
    SQ_FINAL
  } seq_st_t;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_LOW,
    TX_HIGH,
    TX_TAIL
  } tx_st_t;

  // channel bit, control pair "load input and update all", code field, sub bit
  function automatic logic [FRAME_W-1:0] make_frame(input logic chan,
                                                    input logic [CODE_FIELD_W-1:0] code);
    return {chan, 2'b10, code, 1'b0};
  endfunction
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) chain[i] <= 1'b0;
        else if (i == 0) chain[i] <= async_in;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/spi_frame_tx.sv
module spi_frame_tx
  import tcs_pkg::*;
#(
  parameter int SCLK_DIV = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic [FRAME_W-1:0] word,
  output logic               cs_n,
  output logic               sclk,
  output logic               din,
  output logic               done
);
  localparam int CNT_W = (SCLK_DIV > 1) ? $clog2(SCLK_DIV) : 1;
  localparam int BIT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SCLK_DIV - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);

  tx_st_t             st;
  logic [CNT_W-1:0]   cnt;
  logic [BIT_W-1:0]   bits;
  logic [FRAME_W-1:0] sh;

  assign din = sh[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= TX_IDLE;
      cnt  <= '0;
      bits <= '0;
      sh   <= '0;
      cs_n <= 1'b1;
      sclk <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        TX_IDLE: if (go) begin
          sh   <= word;
          cs_n <= 1'b0;
          cnt  <= '0;
          bits <= '0;
          st   <= TX_LOW;
        end
        TX_LOW: begin
          if (cnt == CNT_LAST) begin
            cnt  <= '0;
            sclk <= 1'b1;
            st   <= TX_HIGH;
          end else cnt <= cnt + 1'b1;
        end
        TX_HIGH: begin
          if (cnt == CNT_LAST) begin
            cnt  <= '0;
            sclk <= 1'b0;
            if (bits == BIT_LAST) st <= TX_TAIL;
            else begin
              bits <= bits + 1'b1;
              sh   <= {sh[FRAME_W-2:0], 1'b0};
              st   <= TX_LOW;
            end
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          if (cnt == CNT_LAST) begin
            cnt  <= '0;
            cs_n <= 1'b1;
            done <= 1'b1;
            st   <= TX_IDLE;
          end else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/thresh_cal_seq.sv
module thresh_cal_seq
  import tcs_pkg::*;
#(
  parameter int DAC_W    = 12,
  parameter int SCLK_DIV = 13,
  parameter int SETTLE_W = 16,
  parameter bit CHAN     = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_valid,
  output logic                start_ready,
  output logic                phase_req,
  output logic                phase_dark,
  input  logic                phase_ack,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic                cmp_in,
  output logic                spi_cs_n,
  output logic                spi_sclk,
  output logic                spi_din,
  output logic [DAC_W-1:0]    bright_code,
  output logic [DAC_W-1:0]    dark_code,
  output logic [DAC_W-1:0]    final_code,
  output logic                cal_done,
  output logic                cal_err
);
  localparam logic [DAC_W-1:0] CODE_MAX = '1;

  seq_st_t            st;
  logic               pass_dark;
  logic [DAC_W-1:0]   code;
  logic [SETTLE_W-1:0] settle_cnt;
  logic               tx_go;
  logic               tx_done;
  logic               cmp_s;
  logic [DAC_W:0]     pair_sum;
  logic [DAC_W-1:0]   mid_code;
  logic [FRAME_W-1:0] tx_word;

  assign pair_sum = {1'b0, bright_code} + {1'b0, dark_code};
  assign mid_code = pair_sum[DAC_W:1];
  assign tx_word  = make_frame(CHAN, CODE_FIELD_W'((st == SQ_FINAL) ? mid_code : code));

  assign start_ready = (st == SQ_IDLE);
  assign phase_req   = (st == SQ_REQ);
  assign phase_dark  = pass_dark;

  cmp_sync #(.STAGES(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (cmp_in),
    .sync_out (cmp_s)
  );

  spi_frame_tx #(.SCLK_DIV(SCLK_DIV)) u_tx (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (tx_go),
    .word  (tx_word),
    .cs_n  (spi_cs_n),
    .sclk  (spi_sclk),
    .din   (spi_din),
    .done  (tx_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= SQ_IDLE;
      pass_dark   <= 1'b0;
      code        <= '0;
      settle_cnt  <= '0;
      tx_go       <= 1'b0;
      bright_code <= '0;
      dark_code   <= '0;
      final_code  <= '0;
      cal_done    <= 1'b0;
      cal_err     <= 1'b0;
    end else begin
      tx_go <= 1'b0;
      case (st)
        SQ_IDLE: if (start_valid) begin
          pass_dark <= 1'b0;
          cal_done  <= 1'b0;
          cal_err   <= 1'b0;
          st        <= SQ_REQ;
        end
        SQ_REQ: if (phase_ack) begin
          code  <= '0;
          tx_go <= 1'b1;
          st    <= SQ_WRITE;
        end
        SQ_WRITE: if (tx_done) begin
          settle_cnt <= '0;
          st         <= SQ_SETTLE;
        end
        SQ_SETTLE: begin
          if (settle_cnt == settle_cycles) begin
            if (cmp_s) begin
              if (!pass_dark) begin
                bright_code <= code;
                pass_dark   <= 1'b1;
                st          <= SQ_REQ;
              end else begin
                dark_code <= code;
                tx_go     <= 1'b1;
                st        <= SQ_FINAL;
              end
            end else if (code == CODE_MAX) begin
              cal_err <= 1'b1;
              st      <= SQ_IDLE;
            end else begin
              code  <= code + 1'b1;
              tx_go <= 1'b1;
              st    <= SQ_WRITE;
            end
          end else settle_cnt <= settle_cnt + 1'b1;
        end
        default: if (tx_done) begin
          final_code <= mid_code;
          cal_done   <= 1'b1;
          st         <= SQ_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/tcs_checker.sv
module tcs_checker #(
  parameter int SCLK_DIV = 13,
  parameter int SETTLE_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_ready,
  input logic                phase_req,
  input logic                phase_dark,
  input logic                phase_ack,
  input logic [SETTLE_W-1:0] settle_cycles,
  input logic                spi_cs_n,
  input logic                spi_sclk,
  input logic                spi_din,
  input logic                cal_done,
  input logic                cal_err
);
  logic        sclk_q;
  int unsigned half_cnt;
  int unsigned gap_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q   <= 1'b0;
      half_cnt <= 0;
      gap_cnt  <= 0;
    end else begin
      sclk_q   <= spi_sclk;
      half_cnt <= (spi_sclk != sclk_q) ? 0 : half_cnt + 1;
      gap_cnt  <= spi_cs_n ? gap_cnt + 1 : 0;
    end
  end

  AST_SCLK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk); // R3
  AST_HIGH_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q && !spi_sclk) |-> (half_cnt == SCLK_DIV - 1)); // R3
  AST_DIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && sclk_q) |-> $stable(spi_din)); // R2
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_req && !phase_ack) |=> (phase_req && $stable(phase_dark))); // R8
  AST_REQ_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    phase_req |-> spi_cs_n); // R8
  AST_IDLE_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    start_ready |-> spi_cs_n); // R9
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cal_done && cal_err)); // R7
  AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && gap_cnt != 0) |-> (gap_cnt > settle_cycles)); // R10
endmodule

bind thresh_cal_seq tcs_checker #(.SCLK_DIV(SCLK_DIV), .SETTLE_W(SETTLE_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_ready   (start_ready),
  .phase_req     (phase_req),
  .phase_dark    (phase_dark),
  .phase_ack     (phase_ack),
  .settle_cycles (settle_cycles),
  .spi_cs_n      (spi_cs_n),
  .spi_sclk      (spi_sclk),
  .spi_din       (spi_din),
  .cal_done      (cal_done),
  .cal_err       (cal_err)
);

// File: tb/thresh_cal_seq_test.sv
module thresh_cal_seq_test;
  localparam int DAC_W    = 6;
  localparam int SCLK_DIV = 2;
  localparam int SETTLE_W = 4;
  localparam bit CHAN     = 1'b0;
  localparam int CMAX     = (1 << DAC_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_valid = 1'b0;
  logic phase_ack = 1'b0;
  logic [SETTLE_W-1:0] settle_cycles = 4'd3;
  logic cmp_in;
  logic start_ready, phase_req, phase_dark;
  logic spi_cs_n, spi_sclk, spi_din;
  logic [DAC_W-1:0] bright_code, dark_code, final_code;
  logic cal_done, cal_err;

  int checks = 0;
  int errors = 0;
  int cur_thr = 0;
  int dac_val = 0;
  logic [15:0] exp_q[$];

  always #2 clk = ~clk;

  thresh_cal_seq #(.DAC_W(DAC_W), .SCLK_DIV(SCLK_DIV), .SETTLE_W(SETTLE_W), .CHAN(CHAN)) uut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .phase_req(phase_req), .phase_dark(phase_dark), .phase_ack(phase_ack),
    .settle_cycles(settle_cycles), .cmp_in(cmp_in), .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk), .spi_din(spi_din), .bright_code(bright_code),
    .dark_code(dark_code), .final_code(final_code), .cal_done(cal_done), .cal_err(cal_err)
  );

  assign cmp_in = (dac_val >= cur_thr);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] frame_of(input int c);
    return {CHAN, 2'b10, 12'(c), 1'b0};
  endfunction

  // monitor: rebuild frames, model DAC, compare against the scoreboard queue
  logic prev_cs = 1'b1, prev_sclk = 1'b0;
  logic [15:0] shw = '0;
  int rises = 0, low_cnt = 0, gap_cnt = 0;
  bit gap_chk = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (phase_req || start_ready) gap_chk = 0;
      if (!spi_cs_n) begin
        if (prev_cs) begin
          if (gap_chk) check(gap_cnt == settle_cycles + 3, "R10 settle gap", gap_cnt, settle_cycles + 3);
          rises = 0; low_cnt = 0;
        end
        low_cnt++;
        if (!prev_sclk && spi_sclk) begin
          shw = {shw[14:0], spi_din};
          rises++;
        end
      end else begin
        if (!prev_cs) begin
          check(rises == 16, "R3 sclk rises per frame", rises, 16);
          check(low_cnt == 33 * SCLK_DIV, "R3 cs low length", low_cnt, 33 * SCLK_DIV);
          if (exp_q.size() == 0) check(0, "R2 unexpected frame", shw, -1);
          else begin
            logic [15:0] e;
            e = exp_q.pop_front();
            check(shw == e, "R2 R4 R5 frame word", shw, e);
          end
          if (shw[15] == CHAN && shw[14:13] == 2'b10) dac_val = int'(shw[12:1]);
          gap_cnt = 0; gap_chk = 1;
        end
        gap_cnt++;
      end
      prev_cs = spi_cs_n; prev_sclk = spi_sclk;
    end
  end

  // driver: push expected frames, run the stimulus handshakes, check results
  task automatic run_cal(input int tb, input int td, input bit poke_start);
    int exp_b = bright_code, exp_d = dark_code, exp_f = final_code;
    bit e_err = 0;
    int passes = 0, cyc = 0;
    for (int c = 0; c <= ((tb > CMAX) ? CMAX : tb); c++) exp_q.push_back(frame_of(c));
    if (tb > CMAX) e_err = 1;
    else begin
      exp_b = tb;
      for (int c = 0; c <= ((td > CMAX) ? CMAX : td); c++) exp_q.push_back(frame_of(c));
      if (td > CMAX) e_err = 1;
      else begin
        exp_d = td;
        exp_f = (tb + td) >> 1;
        exp_q.push_back(frame_of(exp_f));
      end
    end
    @(negedge clk); start_valid = 1'b1;
    @(negedge clk); start_valid = 1'b0;
    check(start_ready == 0, "R9 busy after start", start_ready, 0);
    while (!(cal_done || cal_err)) begin
      @(negedge clk);
      cyc++;
      phase_ack = 1'b0;
      if (poke_start && cyc == 300) begin
        check(start_ready == 0, "R9 start_ready low mid-run", start_ready, 0);
        start_valid = 1'b1;
        @(negedge clk); start_valid = 1'b0;
      end
      if (phase_req) begin
        check(phase_dark == (passes == 1), "R8 phase_dark", phase_dark, passes == 1);
        for (int w = 0; w < 3; w++) begin
          @(negedge clk);
          check(phase_req && spi_cs_n && phase_dark == (passes == 1), "R8 request held, no frame",
                {phase_req, spi_cs_n}, 3);
        end
        cur_thr = (passes == 0) ? tb : td;
        passes++;
        phase_ack = 1'b1;
      end
    end
    @(negedge clk);
    check(cal_err == e_err, "R7 error flag", cal_err, e_err);
    check(cal_done == !e_err, "R6 done flag", cal_done, !e_err);
    check(bright_code == exp_b, "R4 bright code", bright_code, exp_b);
    check(dark_code == exp_d, "R5 dark code", dark_code, exp_d);
    check(final_code == exp_f, "R6 final code", final_code, exp_f);
    check(start_ready == 1, "R9 ready after run", start_ready, 1);
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R7 leftover expected frames", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 190000) begin
        check(0, "watchdog", wd, 190000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(spi_cs_n == 1 && spi_sclk == 0, "R1 serial idle", {spi_cs_n, spi_sclk}, 2);
    check(start_ready == 1 && phase_req == 0, "R1 handshakes", {start_ready, phase_req}, 2);
    check(cal_done == 0 && cal_err == 0, "R1 flags", {cal_done, cal_err}, 0);
    check(bright_code == 0 && dark_code == 0 && final_code == 0, "R1 codes", final_code, 0);
    run_cal(10, 4, 1'b1);
    run_cal(0, 0, 1'b0);
    run_cal(CMAX, CMAX - 1, 1'b0);
    run_cal(CMAX + 1, 3, 1'b0);
    run_cal(5, CMAX + 1, 1'b0);
    settle_cycles = 4'd1;
    run_cal(20, 31, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule